// File: doc/BRIEF.md
# Banked SRAM Controller with Zero-Fill Engine

This block fronts a main SRAM that is split into equal-size banks. It provides a small register file on a 32-bit register bus, a word-wide data port for ordinary SRAM reads and writes, and a background engine that clears a programmed run of words to zero. The engine writes one word per clock cycle.

Software can switch each bank off with a bit in the configuration register. A bank that is switched off reads as zero on the data port and drops data-port writes. The engine will not clear a range that touches a switched-off bank, or a range that runs past the end of the memory. In that case it flags an error instead.

A clear is started by writing a word-aligned byte address, then a length word with bit 0 set. Software polls bit 0 until it drops, or waits for the interrupt line. Two status flags, "finished" and "refused", are cleared by writing ones to them. Each flag can be masked from the interrupt output.

Top module: `sram_bank_ctl`

## Requirements
- R1: After reset, the bank-config register, the status register, the erase-control register and the erase-address register read 0. The mask register reads 0x3, bank status reads one set bit per bank, and `irq` is low.
- R2: Bit (i+4) of the bank-config register (offset 0x00) switches bank i off. While bank i is off:
  - bit i of bank status (offset 0x2C) reads 0;
  - data-port reads in bank i return 0;
  - data-port writes to bank i are dropped.
- R3: Writing erase-control (offset 0x0C) with bit 0 = 1 while idle starts a clear. Bit 0 reads 1 while the clear runs and 0 once it ends.
- R4: A clear zeroes the words from (erase-address >> 2) through (erase-address >> 2) + erase-control[31:2] inclusive. The low two address bits are ignored, a length field of 0 clears one word, and all other words keep their values.
- R5: A clear of N+1 words writes one word per cycle. Bit 0 reads 1 at exactly N+2 consecutive falling edges, counted from the first falling edge after the starting write.
- R6: A clear whose range touches a switched-off bank, or runs past the last word, writes nothing. It sets status bit 1 (refused) and reads busy at one falling edge only.
- R7: A clear that completes sets status bit 0 (finished) at offset 0x04.
- R8: Writing ones to status bits clears them. Writing 0xFFFFFFFF clears both flags.
- R9: `irq` is high exactly when some status bit is set whose mask bit (offset 0x08, bit 0 for finished, bit 1 for refused) is 0.
- R10: Writes to erase-control or erase-address while a clear is running are ignored. Both registers keep their values.
- R11: Register offsets are 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x2C. Any other offset reads 0, and erase-control reads back its length in bits [31:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_addr | input | MEM_AW | Data-port word address |
| mem_we | input | 1 | Data-port write strobe |
| mem_wdata | input | 32 | Data-port write data |
| mem_rdata | output | 32 | Data-port read data (combinational) |
| irq | output | 1 | Unmasked status pending |

## Verification
The assertions assume that software does not switch a bank off while a clear is sweeping through it. They also assume the data port does not write in the same cycles as the engine, because the engine wins and the data-port write would be lost. The stimulus toggles bank-config bits only while idle, and touches the data port only before a clear starts or after busy reads 0. Every clear in the sweep uses a range whose correctness the bench model decides from the address and length alone.

// File: rtl/sram_bank_pkg.sv
package sram_bank_pkg;
  localparam logic [7:0] OFS_CFG   = 8'h00;
  localparam logic [7:0] OFS_STS   = 8'h04;
  localparam logic [7:0] OFS_MSK   = 8'h08;
  localparam logic [7:0] OFS_ECTL  = 8'h0C;
  localparam logic [7:0] OFS_EADR  = 8'h10;
  localparam logic [7:0] OFS_BSTAT = 8'h2C;

  localparam int STS_DONE  = 0;
  localparam int STS_ERR   = 1;
  localparam int DIS_SHIFT = 4;

  typedef enum logic [1:0] {
    ER_IDLE  = 2'd0,
    ER_CHECK = 2'd1,
    ER_RUN   = 2'd2
  } er_state_e;
endpackage

// File: rtl/sram_bank_regs.sv
module sram_bank_regs
  import sram_bank_pkg::*;
#(
  parameter int NBANKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              done_p,
  input  logic              err_p,
  output logic [NBANKS-1:0] dis,
  output logic              start_p,
  output logic [29:0]       elen,
  output logic [31:0]       eaddr,
  output logic [1:0]        sts,
  output logic              irq
);
  logic [NBANKS-1:0] dis_q, dis_d;
  logic [1:0]        sts_q, sts_d;
  logic [1:0]        msk_q, msk_d;
  logic [29:0]       elen_q, elen_d;
  logic [31:0]       eaddr_q, eaddr_d;
  logic [31:0]       cfg_rd, bst_rd;

  always_comb begin
    dis_d   = dis_q;
    sts_d   = sts_q;
    msk_d   = msk_q;
    elen_d  = elen_q;
    eaddr_d = eaddr_q;
    if (reg_we) begin
      case (reg_addr)
        OFS_CFG:  dis_d = reg_wdata[DIS_SHIFT +: NBANKS];
        OFS_STS:  sts_d = sts_q & ~reg_wdata[1:0];
        OFS_MSK:  msk_d = reg_wdata[1:0];
        OFS_ECTL: if (!busy) elen_d = reg_wdata[31:2];
        OFS_EADR: if (!busy) eaddr_d = reg_wdata;
        default:  ;
      endcase
    end
    if (done_p) sts_d[STS_DONE] = 1'b1;
    if (err_p)  sts_d[STS_ERR]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q   <= '0;
      sts_q   <= '0;
      msk_q   <= 2'b11;
      elen_q  <= '0;
      eaddr_q <= '0;
    end else begin
      dis_q   <= dis_d;
      sts_q   <= sts_d;
      msk_q   <= msk_d;
      elen_q  <= elen_d;
      eaddr_q <= eaddr_d;
    end
  end

  assign start_p = reg_we && (reg_addr == OFS_ECTL) && reg_wdata[0] && !busy;

  always_comb begin
    cfg_rd = '0;
    cfg_rd[DIS_SHIFT +: NBANKS] = dis_q;
    bst_rd = '0;
    bst_rd[NBANKS-1:0] = ~dis_q;
  end

  always_comb begin
    case (reg_addr)
      OFS_CFG:   reg_rdata = cfg_rd;
      OFS_STS:   reg_rdata = {30'd0, sts_q};
      OFS_MSK:   reg_rdata = {30'd0, msk_q};
      OFS_ECTL:  reg_rdata = {elen_q, 1'b0, busy};
      OFS_EADR:  reg_rdata = eaddr_q;
      OFS_BSTAT: reg_rdata = bst_rd;
      default:   reg_rdata = '0;
    endcase
  end

  assign dis   = dis_q;
  assign elen  = elen_q;
  assign eaddr = eaddr_q;
  assign sts   = sts_q;
  assign irq   = |(sts_q & ~msk_q);
endmodule

// File: rtl/sram_bank_eraser.sv
module sram_bank_eraser
  import sram_bank_pkg::*;
#(
  parameter int NBANKS     = 4,
  parameter int BANK_WORDS = 16,
  parameter int MEM_AW     = $clog2(NBANKS * BANK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_p,
  input  logic [29:0]       elen,
  input  logic [31:0]       eaddr,
  input  logic [NBANKS-1:0] dis,
  output logic              busy,
  output logic              done_p,
  output logic              err_p,
  output logic              we,
  output logic [MEM_AW-1:0] waddr
);
  localparam int TOTAL = NBANKS * BANK_WORDS;
  localparam int BAW   = $clog2(BANK_WORDS);

  er_state_e         st_q, st_d;
  logic [MEM_AW-1:0] cur_q, cur_d;
  logic [29:0]       rem_q, rem_d;

  logic [30:0]       startw, endw;
  logic              oor, hit, cur_dis;
  logic [NBANKS-1:0] touch, cur_sel;

  assign startw = {1'b0, eaddr[31:2]};
  assign endw   = startw + {1'b0, elen};
  assign oor    = endw >= 31'(TOTAL);

  for (genvar i = 0; i < NBANKS; i++) begin : g_bank_cmp
    localparam logic [30:0] LO = 31'(i * BANK_WORDS);
    localparam logic [30:0] HI = 31'(i * BANK_WORDS + BANK_WORDS - 1);
    assign touch[i]   = (endw >= LO) && (startw <= HI);
    assign cur_sel[i] = (cur_q >> BAW) == MEM_AW'(i);
  end

  assign hit     = |(touch & dis);
  assign cur_dis = |(cur_sel & dis);

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    rem_d  = rem_q;
    we     = 1'b0;
    done_p = 1'b0;
    err_p  = 1'b0;
    case (st_q)
      ER_IDLE: begin
        if (start_p) st_d = ER_CHECK;
      end
      ER_CHECK: begin
        if (oor || hit) begin
          err_p = 1'b1;
          st_d  = ER_IDLE;
        end else begin
          st_d  = ER_RUN;
          cur_d = startw[MEM_AW-1:0];
          rem_d = elen;
        end
      end
      ER_RUN: begin
        if (cur_dis) begin
          err_p = 1'b1;
          st_d  = ER_IDLE;
        end else begin
          we = 1'b1;
          if (rem_q == '0) begin
            done_p = 1'b1;
            st_d   = ER_IDLE;
          end else begin
            rem_d = rem_q - 30'd1;
            cur_d = cur_q + MEM_AW'(1);
          end
        end
      end
      default: st_d = ER_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ER_IDLE;
      cur_q <= '0;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      rem_q <= rem_d;
    end
  end

  assign busy  = st_q != ER_IDLE;
  assign waddr = cur_q;
endmodule

// File: rtl/sram_bank_array.sv
module sram_bank_array #(
  parameter int NBANKS     = 4,
  parameter int BANK_WORDS = 16,
  parameter int MEM_AW     = $clog2(NBANKS * BANK_WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [31:0]       wdata,
  input  logic [MEM_AW-1:0] raddr,
  input  logic [NBANKS-1:0] dis,
  output logic [31:0]       rdata
);
  localparam int BAW = $clog2(BANK_WORDS);

  logic [31:0]       rd_w [NBANKS];
  logic [NBANKS-1:0] rsel;

  for (genvar i = 0; i < NBANKS; i++) begin : g_bank
    logic [31:0] mem [BANK_WORDS];
    logic        wsel, wen;
    assign wsel    = (waddr >> BAW) == MEM_AW'(i);
    assign rsel[i] = (raddr >> BAW) == MEM_AW'(i);
    assign wen     = we && wsel && !dis[i];
    always_ff @(posedge clk) begin
      if (wen) mem[waddr[BAW-1:0]] <= wdata;
    end
    assign rd_w[i] = dis[i] ? 32'd0 : mem[raddr[BAW-1:0]];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NBANKS; i++) begin
      if (rsel[i]) rdata = rd_w[i];
    end
  end
endmodule

// File: rtl/sram_bank_ctl.sv
module sram_bank_ctl
  import sram_bank_pkg::*;
#(
  parameter int NBANKS     = 4,
  parameter int BANK_WORDS = 16,
  parameter int MEM_AW     = $clog2(NBANKS * BANK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_we,
  input  logic [31:0]       mem_wdata,
  output logic [31:0]       mem_rdata,
  output logic              irq
);
  logic              rst_s1_q, rst_sync_n;
  logic [NBANKS-1:0] dis;
  logic              start_p, er_busy, done_p, err_p, eng_we;
  logic [29:0]       elen;
  logic [31:0]       eaddr;
  logic [1:0]        sts;
  logic [MEM_AW-1:0] eng_waddr, arr_waddr;
  logic [31:0]       arr_wdata;
  logic              arr_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  sram_bank_regs #(.NBANKS(NBANKS)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(er_busy), .done_p(done_p), .err_p(err_p),
    .dis(dis), .start_p(start_p), .elen(elen), .eaddr(eaddr),
    .sts(sts), .irq(irq)
  );

  sram_bank_eraser #(.NBANKS(NBANKS), .BANK_WORDS(BANK_WORDS), .MEM_AW(MEM_AW)) u_eraser (
    .clk(clk), .rst_n(rst_sync_n), .start_p(start_p), .elen(elen),
    .eaddr(eaddr), .dis(dis), .busy(er_busy), .done_p(done_p),
    .err_p(err_p), .we(eng_we), .waddr(eng_waddr)
  );

  assign arr_we    = eng_we || mem_we;
  assign arr_waddr = eng_we ? eng_waddr : mem_addr;
  assign arr_wdata = eng_we ? 32'd0 : mem_wdata;

  sram_bank_array #(.NBANKS(NBANKS), .BANK_WORDS(BANK_WORDS), .MEM_AW(MEM_AW)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(mem_addr), .dis(dis), .rdata(mem_rdata)
  );
endmodule

// File: rtl/sram_bank_ctl_chk.sv
module sram_bank_ctl_chk
  import sram_bank_pkg::*;
#(
  parameter int NBANKS     = 4,
  parameter int BANK_WORDS = 16,
  parameter int MEM_AW     = $clog2(NBANKS * BANK_WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        reg_addr,
  input logic              reg_we,
  input logic [31:0]       reg_wdata,
  input logic              busy,
  input logic              eng_we,
  input logic [MEM_AW-1:0] eng_waddr,
  input logic [NBANKS-1:0] dis,
  input logic [1:0]        sts,
  input logic              done_p,
  input logic              err_p,
  input logic [31:0]       eaddr,
  input logic [29:0]       elen
);
  localparam int BAW = $clog2(BANK_WORDS);
  logic eng_dis;

  always_comb begin
    eng_dis = 1'b0;
    for (int i = 0; i < NBANKS; i++) begin
      if ((eng_waddr >> BAW) == MEM_AW'(i) && dis[i]) eng_dis = 1'b1;
    end
  end

  // R3
  start_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_ECTL && reg_wdata[0] && !busy) |=> busy);

  // R6
  eng_bank_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> !eng_dis);

  // R5
  eng_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> busy);

  // R4
  eng_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && $past(eng_we)) |-> (eng_waddr == $past(eng_waddr) + MEM_AW'(1)));

  // R7
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sts[STS_DONE] || sts[STS_ERR]));

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_STS && (&reg_wdata) && !done_p && !err_p) |=> (sts == 2'b00));

  // R10
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> ($stable(eaddr) && $stable(elen)));
endmodule

bind sram_bank_ctl sram_bank_ctl_chk #(
  .NBANKS(NBANKS), .BANK_WORDS(BANK_WORDS), .MEM_AW(MEM_AW)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .busy(er_busy), .eng_we(eng_we),
  .eng_waddr(eng_waddr), .dis(dis), .sts(sts), .done_p(done_p),
  .err_p(err_p), .eaddr(eaddr), .elen(elen)
);

// File: tb/tb_sram_bank_ctl.sv
`timescale 1ns/1ps
module tb_sram_bank_ctl;
  localparam int NB    = 4;
  localparam int BW    = 16;
  localparam int TOT   = NB * BW;
  localparam int AW    = $clog2(TOT);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    reg_addr;
  logic          reg_we;
  logic [31:0]   reg_wdata, reg_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  logic [31:0] model [TOT];

  always #2.5 clk = ~clk;

  sram_bank_ctl #(.NBANKS(NB), .BANK_WORDS(BW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic mwr(input int w, input logic [31:0] d);
    @(negedge clk);
    mem_addr = AW'(w); mem_wdata = d; mem_we = 1'b1;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  task automatic mrd(input int w, output logic [31:0] d);
    mem_addr = AW'(w);
    #1;
    d = mem_rdata;
  endtask

  function automatic logic [31:0] pat(input int w, input int salt);
    return 32'h5A000000 ^ (32'(w) * 32'h00010203) ^ (32'(salt) << 20);
  endfunction

  task automatic fill(input int salt);
    for (int w = 0; w < TOT; w++) begin
      mwr(w, pat(w, salt));
      model[w] = pat(w, salt);
    end
  endtask

  task automatic verify(input string tag);
    logic [31:0] d;
    for (int w = 0; w < TOT; w++) begin
      mrd(w, d);
      chk(tag, d, model[w]);
    end
  endtask

  // starts a clear and counts falling edges with busy read as 1
  task automatic erase(input logic [31:0] baddr, input int len, output int nbusy);
    logic [31:0] d;
    wr(8'h10, baddr);
    wr(8'h0C, (32'(len) << 2) | 32'd1);
    nbusy = 0;
    for (int k = 0; k < 5000; k++) begin
      rd(8'h0C, d);
      if (!d[0]) break;
      nbusy++;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] d;
    int nb;
    int starts [8] = '{0, 3, 15, 16, 31, 47, 50, 63};
    int lens   [6] = '{0, 1, 2, 15, 16, 33};

    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    mem_addr = '0; mem_we = 1'b0; mem_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd(8'h00, d); chk("R1 cfg", d, 32'h0);
    rd(8'h04, d); chk("R1 sts", d, 32'h0);
    rd(8'h08, d); chk("R1 msk", d, 32'h3);
    rd(8'h0C, d); chk("R1 ectl", d, 32'h0);
    rd(8'h10, d); chk("R1 eadr", d, 32'h0);
    rd(8'h2C, d); chk("R1 bstat", d, 32'hF);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    // R11 unmapped offset
    rd(8'h14, d); chk("R11 unmapped", d, 32'h0);

    // R4 R5 R7 R8 sweep of start and length
    for (int si = 0; si < 8; si++) begin
      for (int li = 0; li < 6; li++) begin
        int s = starts[si];
        int l = lens[li];
        if (s + l < TOT) begin
          fill(si * 6 + li);
          erase(32'(s * 4 + (s % 4)), l, nb);
          for (int w = s; w <= s + l; w++) model[w] = 32'd0;
          chk("R5 busy cycles", 32'(nb), 32'(l + 2));
          rd(8'h04, d); chk("R7 done flag", d, 32'h1);
          chk("R9 masked irq", {31'd0, irq}, 32'h0);
          wr(8'h04, 32'hFFFFFFFF);
          rd(8'h04, d); chk("R8 w1c", d, 32'h0);
          verify("R4 contents");
        end
      end
    end

    // R4 whole bank 1 with one-bank length word
    fill(99);
    wr(8'h10, 32'(BW * 4));
    wr(8'h0C, (((32'(BW * 4) - 32'd4) >> 2) << 2) | 32'd1);
    repeat (BW + 4) @(negedge clk);
    for (int w = BW; w < 2 * BW; w++) model[w] = 32'd0;
    rd(8'h0C, d); chk("R3 idle after", d, ((32'(BW) - 32'd1) << 2));
    verify("R4 bank");
    wr(8'h04, 32'hFFFFFFFF);

    // R9 irq with done unmasked
    wr(8'h08, 32'h2);
    erase(32'd8, 0, nb);
    model[2] = 32'd0;
    chk("R9 irq done", {31'd0, irq}, 32'h1);
    wr(8'h04, 32'h1);
    chk("R9 irq cleared", {31'd0, irq}, 32'h0);

    // R2 bank 2 off
    fill(7);
    wr(8'h00, 32'h1 << (2 + 4));
    rd(8'h00, d); chk("R2 cfg", d, 32'h40);
    rd(8'h2C, d); chk("R2 bstat", d, 32'hB);
    mrd(2 * BW + 1, d); chk("R2 off reads 0", d, 32'h0);
    mwr(2 * BW + 1, 32'hDEADBEEF);
    // R6 range through bank 2
    wr(8'h08, 32'h1);
    erase(32'd30 * 4, 10, nb);
    chk("R6 busy cycles", 32'(nb), 32'd1);
    rd(8'h04, d); chk("R6 err flag", d, 32'h2);
    chk("R9 irq err", {31'd0, irq}, 32'h1);
    wr(8'h04, 32'hFFFFFFFF);
    wr(8'h00, 32'h0);
    verify("R6 no writes");
    mrd(2 * BW + 1, d); chk("R2 dropped write", d, pat(2 * BW + 1, 7));
    // R6 past the end
    erase(32'd60 * 4, 10, nb);
    rd(8'h04, d); chk("R6 oor err", d, 32'h2);
    verify("R6 oor no writes");
    wr(8'h04, 32'hFFFFFFFF);

    // R10 writes while running
    wr(8'h10, 32'd0);
    wr(8'h0C, (32'd40 << 2) | 32'd1);
    wr(8'h10, 32'h80);
    wr(8'h0C, (32'd3 << 2) | 32'd1);
    rd(8'h10, d); chk("R10 eadr held", d, 32'h0);
    rd(8'h0C, d); chk("R10 ectl held", d, (32'd40 << 2) | 32'd1);
    repeat (50) @(negedge clk);
    for (int w = 0; w <= 40; w++) model[w] = 32'd0;
    rd(8'h0C, d); chk("R3 cleared", d, 32'd40 << 2);
    verify("R10 contents");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule